// File: doc/BRIEF.md
# Clock Generator Configuration Slave

This block is the serial control port of a clock generator. It sits on a two-wire serial bus as a slave and holds six 8-bit configuration bytes that steer the generator: frequency selection, spread modulation and per-output gating. A host updates them with a block-write transaction and reads them back with a block-read transaction. Access is strictly sequential from byte 0. There is no register addressing. On a write, a command byte and a count byte must be sent first, and the slave ignores their values. On a read, the slave sends a count byte ahead of the data.

SCL and SDA are oversampled by a fast system clock through two-flop synchronizers. The slave pulls SDA low through an open-drain enable. Besides the raw register image, the block decodes the control byte. It outputs the spread-enable, spread-direction and output-disable controls, and a 4-bit frequency code. That code comes either from strap pins captured during reset or from bits of byte 0.

Top module: `clkgen_cfg_slave`

## Requirements
- R1: After reset the bytes 0..5 read 0x00, 0x1F, 0xFF, 0xFF, 0x6B, 0x00 (cfg_image bits [8k+7:8k] hold byte k), and sda_pull_low is 0.
- R2: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. For any other address the slave gives no acknowledge, ignores the rest of the transaction and leaves every register unchanged.
- R3: On a write, the two bytes after the address (command and count) are acknowledged and discarded. Each following data byte is acknowledged and stored into byte 0, 1, 2 and so on, in arrival order.
- R4: A stop after any complete data byte keeps the bytes already received. A byte cut short by a stop is not stored. sda_pull_low is 0 in the cycle after a stop is seen.
- R5: A seventh data byte in one write is not acknowledged and changes no register.
- R6: On a read, after the 0xD3 acknowledge, the slave sends the count 0x06 and then bytes 0 through 5, most significant bit first. Each byte is followed by a host acknowledge slot.
- R7: A host NACK during a read ends the transfer. The slave then keeps SDA released until the next start condition.
- R8: When byte 0 bit 3 is 0, freq_code equals the latched strap value. When it is 1, freq_code is {bit2, bit6, bit5, bit4} of byte 0 (MSB first). A write that changes the source and the code together moves freq_code straight from the old value to the new one.
- R9: spread_en follows byte 0 bit 1, outputs_off follows bit 0, and spread_down follows bit 7 (0 = centre spread, 1 = down spread).
- R10: fs_strap is sampled only while rst is high. Later changes on the pins do not affect freq_code.
- R11: sda_pull_low changes only while SCL is low. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND of all drivers) |
| fs_strap | input | 4 | Frequency-select strap pins |
| sda_pull_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| cfg_image | output | 48 | The six configuration bytes, byte k at bits [8k+7:8k] |
| freq_code | output | 4 | Selected frequency code |
| spread_en | output | 1 | Spread modulation enable |
| spread_down | output | 1 | Spread direction: 1 down, 0 centre |
| outputs_off | output | 1 | Request to float all clock outputs |

## Verification
A single write commit of byte 0 can move the frequency source bit and the register code bits in the same cycle. If the two were applied one after the other, freq_code would show a mixed value for a cycle. The bench provokes this by rewriting byte 0 from strap-sourced to register-sourced with a code that differs from the strap. While that write runs, it watches freq_code on every clock and counts any value that is neither the old code nor the new one. It also compares the register image and the decoded controls against its own model on every clock outside write windows.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } link_state_t;

  localparam int FREQ_W = 4;

endpackage

// File: rtl/cfgslv_line_sync.sv
module cfgslv_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_q, sda_q, scl_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl  = scl_pipe[STAGES-1];
  assign sda_lvl  = sda_pipe[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/cfgslv_regbank.sv
module cfgslv_regbank #(
  parameter int              NREG = 6,
  parameter int              DW   = 8,
  parameter logic [NREG*DW-1:0] INIT = '0,
  localparam int             IW   = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] image
);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        image[g*DW +: DW] <= INIT[g*DW +: DW];
      else if (wr_en && wr_idx == IW'(g))
        image[g*DW +: DW] <= wr_data;
    end
  end

endmodule

// File: rtl/cfgslv_freq_sel.sv
module cfgslv_freq_sel
  import cfgslv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [FREQ_W-1:0] strap,
  input  logic [7:0]        ctrl,
  output logic [FREQ_W-1:0] freq_code,
  output logic              spread_en,
  output logic              spread_down,
  output logic              outputs_off
);

  logic [FREQ_W-1:0] strap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q     <= strap;
      freq_code   <= strap;
      spread_en   <= 1'b0;
      spread_down <= 1'b0;
      outputs_off <= 1'b0;
    end else begin
      freq_code   <= ctrl[3] ? {ctrl[2], ctrl[6], ctrl[5], ctrl[4]} : strap_q;
      spread_en   <= ctrl[1];
      spread_down <= ctrl[7];
      outputs_off <= ctrl[0];
    end
  end

endmodule

// File: rtl/clkgen_cfg_slave.sv
module clkgen_cfg_slave
  import cfgslv_pkg::*;
#(
  parameter int                 NREG     = 6,
  parameter int                 DW       = 8,
  parameter int                 SYNC     = 2,
  parameter logic [DW-2:0]      DEV_ADDR = 7'h69,
  parameter logic [NREG*DW-1:0] DEFAULTS = 48'h00_6B_FF_FF_1F_00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [FREQ_W-1:0]  fs_strap,
  output logic               sda_pull_low,
  output logic [NREG*DW-1:0] cfg_image,
  output logic [FREQ_W-1:0]  freq_code,
  output logic               spread_en,
  output logic               spread_down,
  output logic               outputs_off
);

  localparam int            IW         = $clog2(NREG);
  localparam int            XW         = $clog2(NREG + 4);
  localparam int            BW         = $clog2(DW);
  localparam int            FIRST_DATA = 3;
  localparam logic [DW-1:0] COUNT_BYTE = DW'(NREG);

  logic sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

  cfgslv_line_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  link_state_t   state;
  logic [DW-1:0] sh;
  logic [BW-1:0] bcnt;
  logic [XW-1:0] idx;
  logic          rw, full;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_byte;

  cfgslv_regbank #(.NREG(NREG), .DW(DW), .INIT(DEFAULTS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .image(cfg_image)
  );

  cfgslv_freq_sel u_freq (
    .clk(clk), .rst(rst), .strap(fs_strap), .ctrl(cfg_image[7:0]),
    .freq_code(freq_code), .spread_en(spread_en),
    .spread_down(spread_down), .outputs_off(outputs_off)
  );

  // next byte to transmit: idx k (1..NREG) selects register k-1
  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NREG; i++)
      if (XW'(i + 1) == idx) rd_byte = cfg_image[i*DW +: DW];
  end

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      state        <= ST_IDLE;
      sh           <= '0;
      bcnt         <= '0;
      idx          <= '0;
      rw           <= 1'b0;
      full         <= 1'b0;
      sda_pull_low <= 1'b0;
      wr_idx       <= '0;
      wr_data      <= '0;
    end else if (start_ev) begin
      state        <= ST_RX;
      bcnt         <= '0;
      idx          <= '0;
      rw           <= 1'b0;
      full         <= 1'b0;
      sda_pull_low <= 1'b0;
    end else if (stop_ev) begin
      state        <= ST_IDLE;
      sda_pull_low <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && !full) begin
            sh <= {sh[DW-2:0], sda_lvl};
            if (bcnt == BW'(DW - 1)) full <= 1'b1;
            else                     bcnt <= bcnt + 1'b1;
          end else if (scl_fall && full) begin
            if (idx == '0) begin
              if (sh[DW-1:1] == DEV_ADDR) begin
                rw           <= sh[0];
                sda_pull_low <= 1'b1;
                state        <= ST_RX_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (idx < XW'(FIRST_DATA)) begin
              sda_pull_low <= 1'b1;
              state        <= ST_RX_ACK;
            end else if (idx < XW'(FIRST_DATA + NREG)) begin
              wr_en        <= 1'b1;
              wr_idx       <= IW'(idx - XW'(FIRST_DATA));
              wr_data      <= sh;
              sda_pull_low <= 1'b1;
              state        <= ST_RX_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            idx  <= idx + 1'b1;
            bcnt <= '0;
            full <= 1'b0;
            if (rw) begin
              sh           <= COUNT_BYTE;
              sda_pull_low <= ~COUNT_BYTE[DW-1];
              state        <= ST_TX;
            end else begin
              sda_pull_low <= 1'b0;
              state        <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bcnt == BW'(DW - 1)) begin
              sda_pull_low <= 1'b0;
              full         <= 1'b0;
              state        <= ST_TX_ACK;
            end else begin
              sh           <= {sh[DW-2:0], 1'b0};
              sda_pull_low <= ~sh[DW-2];
              bcnt         <= bcnt + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            full <= ~sda_lvl;
          end else if (scl_fall) begin
            if (full && idx < XW'(NREG + 1)) begin
              idx          <= idx + 1'b1;
              sh           <= rd_byte;
              sda_pull_low <= ~rd_byte[DW-1];
              bcnt         <= '0;
              full         <= 1'b0;
              state        <= ST_TX;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clkgen_cfg_slave_chk.sv
module clkgen_cfg_slave_chk
  import cfgslv_pkg::*;
#(
  parameter int NREG = 6,
  parameter int DW   = 8,
  localparam int IW  = $clog2(NREG)
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_fall,
  input logic               start_ev,
  input logic               stop_ev,
  input logic               sda_pull_low,
  input logic               wr_en,
  input logic [IW-1:0]      wr_idx,
  input logic [NREG*DW-1:0] cfg_image,
  input logic [FREQ_W-1:0]  freq_code,
  input link_state_t        state
);

  // R11
  sda_moves_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_pull_low != $past(sda_pull_low)) |-> $past(scl_fall || start_ev || stop_ev));

  // R4
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_pull_low);

  // R3
  regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(cfg_image));

  // R5
  write_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx < IW'(NREG)));

  // R10
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_image[3] && !$past(cfg_image[3])) |=> $stable(freq_code));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_pull_low);

endmodule

bind clkgen_cfg_slave clkgen_cfg_slave_chk #(.NREG(NREG), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .scl_fall(scl_fall), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_pull_low(sda_pull_low), .wr_en(wr_en),
  .wr_idx(wr_idx), .cfg_image(cfg_image), .freq_code(freq_code),
  .state(state)
);

// File: tb/test_clkgen_cfg_slave.sv
`timescale 1ns/1ps
module test_clkgen_cfg_slave;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_scl = 1'b1;
  logic        host_sda = 1'b1;
  logic [3:0]  fs_strap = 4'b1010;
  logic        sda_pull_low;
  logic [47:0] cfg_image;
  logic [3:0]  freq_code;
  logic        spread_en, spread_down, outputs_off;
  logic        sda_bus;

  always #2.5 clk = ~clk;
  assign sda_bus = host_sda & ~sda_pull_low;

  clkgen_cfg_slave i_clkgen_cfg_slave (
    .clk(clk), .rst(rst), .scl_in(host_scl), .sda_in(sda_bus),
    .fs_strap(fs_strap), .sda_pull_low(sda_pull_low), .cfg_image(cfg_image),
    .freq_code(freq_code), .spread_en(spread_en), .spread_down(spread_down),
    .outputs_off(outputs_off)
  );

  int          n_checks = 0;
  int          n_err = 0;
  bit          done = 1'b0;
  bit          cmp_on = 1'b0;
  logic [7:0]  model [6];
  logic [3:0]  strap_lat = 4'b1010;
  logic [7:0]  wbuf [8];
  int          drv_viol = 0;
  logic        prev_drv = 1'b0;
  bit          mon_on = 1'b0;
  logic [3:0]  mon_old, mon_new;
  int          glitches = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] model_img();
    logic [47:0] r;
    for (int k = 0; k < 6; k++) r[k*8 +: 8] = model[k];
    return r;
  endfunction

  function automatic logic [3:0] model_freq();
    return model[0][3] ? {model[0][2], model[0][6], model[0][5], model[0][4]} : strap_lat;
  endfunction

  // per-clock comparison with the reference model
  always @(negedge clk) begin
    if (cmp_on && !rst && !done) begin
      check(cfg_image == model_img(), "R3 image vs model", cfg_image, model_img());
      check({freq_code, spread_en, spread_down, outputs_off} ==
            {model_freq(), model[0][1], model[0][7], model[0][0]},
            "R8/R9 decode vs model",
            {freq_code, spread_en, spread_down, outputs_off},
            {model_freq(), model[0][1], model[0][7], model[0][0]});
    end
    if (!rst && sda_pull_low != prev_drv && host_scl) drv_viol++;
    prev_drv = sda_pull_low;
    if (mon_on && freq_code != mon_old && freq_code != mon_new) glitches++;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wt(10); host_scl = 1'b1; wt(10);
    host_sda = 1'b0; wt(10); host_scl = 1'b0; wt(10);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wt(10); host_scl = 1'b1; wt(10); host_sda = 1'b1; wt(10);
  endtask

  task automatic bit_wr(input logic v);
    host_sda = v; wt(10); host_scl = 1'b1; wt(20); host_scl = 1'b0; wt(10);
  endtask

  task automatic bit_rd(output logic r);
    host_sda = 1'b1; wt(10); host_scl = 1'b1; wt(10);
    r = sda_bus; wt(10); host_scl = 1'b0; wt(10);
  endtask

  task automatic byte_wr(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) bit_wr(b[i]);
    bit_rd(r);
    acked = !r;
  endtask

  task automatic byte_rd(output logic [7:0] v, input logic host_ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_rd(r);
      v[i] = r;
    end
    bit_wr(!host_ack);
  endtask

  task automatic do_write(input int n, input int partial_bits);
    logic a;
    cmp_on = 1'b0;
    bus_start();
    byte_wr(8'hD2, a);  check(a, "R2 write address ack", a, 1);
    byte_wr(8'h5A, a);  check(a, "R3 command byte ack", a, 1);
    byte_wr(8'hC3, a);  check(a, "R3 count byte ack", a, 1);
    for (int i = 0; i < n; i++) begin
      byte_wr(wbuf[i], a);
      if (i < 6) begin
        check(a, "R3 data byte ack", a, 1);
        model[i] = wbuf[i];
      end else begin
        check(!a, "R5 seventh byte nack", a, 0);
        break;
      end
    end
    for (int i = 0; i < partial_bits; i++) bit_wr(1'b1);
    bus_stop();
    wt(1);
    check(!sda_pull_low, "R4 released after stop", sda_pull_low, 0);
    wt(8);
    cmp_on = 1'b1;
  endtask

  task automatic do_read(input int nbytes);
    logic       a;
    logic [7:0] v;
    bus_start();
    byte_wr(8'hD3, a);
    check(a, "R6 read address ack", a, 1);
    byte_rd(v, 1'b1);
    check(v == 8'h06, "R6 byte count", v, 8'h06);
    for (int i = 0; i < nbytes; i++) begin
      byte_rd(v, i < nbytes - 1);
      check(v == model[i], "R6 read data", v, model[i]);
    end
    if (nbytes < 6) begin
      for (int i = 0; i < 8; i++) begin
        bit_rd(a);
        check(a == 1'b1, "R7 released after nack", a, 1);
      end
    end
    bus_stop();
    wt(8);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    logic a;
    wt(10);
    rst = 1'b0;
    wt(1);
    fs_strap = 4'b0101;
    wt(5);
    // R1 reset image and bus release
    check(cfg_image == 48'h00_6B_FF_FF_1F_00, "R1 reset image", cfg_image, 48'h006BFFFF1F00);
    check(!sda_pull_low, "R1 sda released", sda_pull_low, 0);
    check(freq_code == 4'hA, "R10 strap latched in reset", freq_code, 4'hA);
    check({spread_en, spread_down, outputs_off} == 3'b000, "R9 reset controls",
          {spread_en, spread_down, outputs_off}, 0);
    for (int k = 0; k < 6; k++) model[k] = cfg_image[k*8 +: 8];
    cmp_on = 1'b1;

    // full six-byte write: byte0 = 1000_0011
    wbuf[0] = 8'h83; wbuf[1] = 8'h11; wbuf[2] = 8'h22;
    wbuf[3] = 8'h33; wbuf[4] = 8'h44; wbuf[5] = 8'h55;
    do_write(6, 0);
    check({spread_en, spread_down, outputs_off} == 3'b111, "R9 control bits set",
          {spread_en, spread_down, outputs_off}, 3'b111);
    check(freq_code == 4'hA, "R8 strap source", freq_code, 4'hA);
    do_read(6);

    // short write: source switches to register code 0xD in one commit
    mon_old = 4'hA; mon_new = 4'hD; mon_on = 1'b1;
    wbuf[0] = 8'h5C; wbuf[1] = 8'hA5;
    do_write(2, 0);
    mon_on = 1'b0;
    check(glitches == 0, "R8 no mixed code", glitches, 0);
    check(freq_code == 4'hD, "R8 register code", freq_code, 4'hD);
    check(cfg_image[23:16] == 8'h22, "R4 untouched byte kept", cfg_image[23:16], 8'h22);
    check({spread_en, spread_down, outputs_off} == 3'b000, "R9 control bits clear",
          {spread_en, spread_down, outputs_off}, 0);

    // seven data bytes: last one refused
    wbuf[0] = 8'h68; wbuf[1] = 8'h01; wbuf[2] = 8'h02; wbuf[3] = 8'h03;
    wbuf[4] = 8'h04; wbuf[5] = 8'h05; wbuf[6] = 8'hEE;
    do_write(7, 0);
    check(freq_code == 4'h6, "R8 register code 6", freq_code, 4'h6);
    check(cfg_image[7:0] == 8'h68, "R5 byte0 not overwritten", cfg_image[7:0], 8'h68);

    // one byte then a cut-off byte
    wbuf[0] = 8'h10;
    do_write(1, 4);
    check(cfg_image[15:8] == 8'h01, "R4 partial byte dropped", cfg_image[15:8], 8'h01);
    check(freq_code == 4'hA, "R10 strap kept after pin change", freq_code, 4'hA);

    // foreign addresses
    bus_start();
    byte_wr(8'hA4, a);
    check(!a, "R2 foreign address nack", a, 0);
    byte_wr(8'hFF, a);
    check(!a, "R2 rest ignored", a, 0);
    bus_stop();
    bus_start();
    byte_wr(8'hD0, a);
    check(!a, "R2 near address nack", a, 0);
    bus_stop();
    wt(8);
    check(cfg_image == model_img(), "R2 registers unchanged", cfg_image, model_img());

    // early NACK then a fresh full read
    do_read(2);
    do_read(6);

    check(drv_viol == 0, "R11 sda moved with scl high", drv_viol, 0);
    wt(10);
    finish_run();
  end

endmodule